// File: doc/BRIEF.md
# Programmable-Format Asynchronous Serial Port

This block is a full-duplex asynchronous serial transmitter and receiver that a host drives through a small byte-wide register file. A 16-bit divisor, written as a low byte and a high byte, sets a tick that runs at sixteen times the bit rate. Each bit on the line therefore lasts 16 × divisor system clocks.

The frame format is set by one register. It selects 5 to 8 data bits, one or two stop bits, and no, even or odd parity. On each side a holding register sits in front of the shift register. The host can queue one byte while another is on the line, and a received byte waits in its holding register while the next frame arrives.

A status register reports receive data ready, overrun, parity error, framing error, transmit holding empty and transmitter idle. One interrupt line combines a receive-ready source and a transmit-empty source, and each source has its own enable.

Top module: `sio_uart`

## Requirements
- R1: After reset the status reads 0x30 (only holding empty and idle set), the line output is high, the interrupt is low, and both divisor bytes read 0.
- R2: Register map: 0 data, 1 divisor low byte, 2 divisor high byte, 3 format, 4 interrupt enable, 5 status. The divisor bytes read back as written, and every bit on the line lasts exactly 16 × divisor clocks.
- R3: With a divisor of zero no tick is produced, and a queued byte is not sent (the line stays high) until a nonzero divisor is written.
- R4: A transmitted frame is a low start bit, then the data bits least significant first, then parity if enabled, then the stop bits. Format bits [1:0] hold the data length minus 5.
- R5: Format bits [4:3] pick the parity: 01 even (the data bits plus the parity bit hold an even number of ones), 10 odd, 00 or 11 none. Format bit 2 set gives two stop bits.
- R6: Status bit 4 (holding empty) clears when the data register is written and sets when that byte moves to the shifter. Status bit 5 (idle) is set only when both holding register and shifter are empty. A byte written while another is on the line follows it.
- R7: The receiver samples each bit at its middle (16 ticks apart). A start bit that is no longer low 8 ticks after the falling edge is dropped and yields no byte.
- R8: Status bit 0 (data ready) sets when a frame completes, and a read of the data register clears it. The received byte is right-aligned with the unused upper bits zero.
- R9: When a frame completes while data ready is still set, status bit 1 (overrun) sets and the newer byte replaces the older one.
- R10: Status bit 2 records a parity mismatch and bit 3 records a first stop bit sampled low. These two bits and overrun stay set until the status register is read. After a framing error the receiver waits for the line to go high before it looks for a new start bit.
- R11: Interrupt enable bit 0 gates data ready and bit 1 gates holding empty. The interrupt output is the OR of the two gated sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives read side effects) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench measures the exact start-to-data-bit edge spacing at a divisor of 3. A tick generator that is off by one, or that counts 15 or 17 ticks per bit, fails this check at once. It holds a byte behind a zero divisor and watches the line, which catches a generator that runs freely at zero. It sends a low pulse shorter than half a bit, which a receiver lacking the mid-bit recheck would turn into a byte of garbage. It also sends 5-bit, parity and two-stop frames; a wrong parity sense, a missing stop bit or data that is not right-aligned shows up as a bit mismatch on the line or a wrong read value. A frame with a low first stop bit checks that the receiver does not treat the rest of that stop bit as a new start. Two unread frames in a row check that the overrun flag is set and that the newer byte is kept.

// File: rtl/sio_pkg.sv
// sio_pkg: shared register addresses and the format-register layout for the
// asynchronous serial port. Assumes an 8-bit host data path.
package sio_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_DATA = 3'd0;
    localparam logic [ADDR_W-1:0] A_DIVL = 3'd1;
    localparam logic [ADDR_W-1:0] A_DIVH = 3'd2;
    localparam logic [ADDR_W-1:0] A_FMT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_IEN  = 3'd4;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd5;

    typedef enum logic [1:0] {
        PAR_NONE  = 2'b00,
        PAR_EVEN  = 2'b01,
        PAR_ODD   = 2'b10,
        PAR_NONE2 = 2'b11
    } par_e;

    // Format register fields: [4:3] parity, [2] two stop bits, [1:0] length-5
    typedef struct packed {
        par_e       par;
        logic       two_stop;
        logic [1:0] len_m5;
    } fmt_t;

    function automatic logic [3:0] data_bits(fmt_t f);
        return 4'd5 + {2'b00, f.len_m5};
    endfunction

    function automatic logic parity_on(fmt_t f);
        return (f.par == PAR_EVEN) || (f.par == PAR_ODD);
    endfunction
endpackage

// File: rtl/sio_baud.sv
// sio_baud: makes a one-clock tick every DIV clocks (16x the bit rate).
// Assumes the divisor may change at any time; a zero divisor holds it reset.
module sio_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Count up to div-1, emit a tick and wrap; zero divisor parks the counter
    always_ff @(posedge clk) begin
        if (!rst_n || div == '0) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= div - 1'b1) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/sio_tx.sv
// sio_tx: holding register plus frame shifter for the serial transmitter.
// Assumes fmt is stable while a frame is on the line; frames load on a tick.
module sio_tx
    import sio_pkg::*;
#(
    parameter int FRAME_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  fmt_t              fmt,
    input  logic              load,
    input  logic [DATA_W-1:0] ldata,
    output logic              txd,
    output logic              thr_empty,
    output logic              idle
);
    localparam int CNT_W = $clog2(FRAME_W + 1);

    logic [DATA_W-1:0]  hold;
    logic               hold_full;
    logic [FRAME_W-1:0] shreg, frame;
    logic [3:0]         sub;
    logic [CNT_W-1:0]   left;
    logic               busy;
    logic [3:0]         nd;
    logic [DATA_W-1:0]  masked;
    logic               pbit;
    logic [CNT_W-1:0]   nbits;

    assign nd     = data_bits(fmt);
    assign masked = hold & (8'hFF >> (4'd8 - nd));
    assign pbit   = (fmt.par == PAR_ODD) ? ~^masked : ^masked;
    assign nbits  = CNT_W'(4'd1 + nd + {3'b000, parity_on(fmt)} + (fmt.two_stop ? 4'd2 : 4'd1));

    // Assemble the outgoing frame, line order from bit 0, idle-high filler
    always_comb begin
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (4'(i) < nd) frame[1+i] = hold[i];
        end
        if (parity_on(fmt)) frame[4'd1 + nd] = pbit;
    end

    // Shift one bit per 16 ticks; pull the holding register in when free
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold      <= '0;
            hold_full <= 1'b0;
            shreg     <= '1;
            sub       <= '0;
            left      <= '0;
            busy      <= 1'b0;
        end else begin
            if (busy && tick) begin
                if (sub == 4'd15) begin
                    sub   <= '0;
                    shreg <= {1'b1, shreg[FRAME_W-1:1]};
                    if (left == CNT_W'(1)) busy <= 1'b0;
                    else                   left <= left - 1'b1;
                end else begin
                    sub <= sub + 1'b1;
                end
            end else if (!busy && hold_full && tick) begin
                shreg     <= frame;
                busy      <= 1'b1;
                sub       <= '0;
                left      <= nbits;
                hold_full <= 1'b0;
            end
            if (load) begin
                hold      <= ldata;
                hold_full <= 1'b1;
            end
        end
    end

    assign txd       = busy ? shreg[0] : 1'b1;
    assign thr_empty = !hold_full;
    assign idle      = !busy && !hold_full;
endmodule

// File: rtl/sio_rx.sv
// sio_rx: start detection, mid-bit sampling and frame checking for the
// receiver. Assumes rxd is asynchronous; it is synchronised here.
module sio_rx
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  fmt_t              fmt,
    input  logic              rxd,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              perr,
    output logic              ferr
);
    typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAITHI} rx_st_e;

    rx_st_e            st;
    logic              s1, s2;
    logic [3:0]        sub;
    logic [2:0]        idx;
    logic [DATA_W-1:0] sh;
    logic              acc, pe;
    logic [3:0]        nd;

    assign nd = data_bits(fmt);

    // Two-flop synchroniser for the incoming line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= rxd;
            s2 <= s1;
        end
    end

    // Frame state machine, sampling on tick 8 of each bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= S_IDLE;
            sub  <= '0;
            idx  <= '0;
            sh   <= '0;
            acc  <= 1'b0;
            pe   <= 1'b0;
            done <= 1'b0;
            data <= '0;
            perr <= 1'b0;
            ferr <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                S_IDLE: if (tick && !s2) begin
                    st  <= S_START;
                    sub <= '0;
                end
                S_START: if (tick) begin
                    if (sub == 4'd7) begin
                        if (!s2) begin
                            st  <= S_DATA;
                            sub <= '0;
                            idx <= '0;
                            acc <= 1'b0;
                            pe  <= 1'b0;
                        end else begin
                            st <= S_IDLE;
                        end
                    end else begin
                        sub <= sub + 1'b1;
                    end
                end
                S_DATA: if (tick) begin
                    if (sub == 4'd15) begin
                        sub <= '0;
                        sh  <= {s2, sh[DATA_W-1:1]};
                        acc <= acc ^ s2;
                        idx <= idx + 1'b1;
                        if (idx == 3'(nd - 4'd1)) st <= parity_on(fmt) ? S_PAR : S_STOP;
                    end else begin
                        sub <= sub + 1'b1;
                    end
                end
                S_PAR: if (tick) begin
                    if (sub == 4'd15) begin
                        sub <= '0;
                        pe  <= (fmt.par == PAR_ODD) ? (s2 == acc) : (s2 != acc);
                        st  <= S_STOP;
                    end else begin
                        sub <= sub + 1'b1;
                    end
                end
                S_STOP: if (tick) begin
                    if (sub == 4'd15) begin
                        sub  <= '0;
                        done <= 1'b1;
                        data <= sh >> (4'd8 - nd);
                        perr <= pe;
                        ferr <= !s2;
                        st   <= s2 ? S_IDLE : S_WAITHI;
                    end else begin
                        sub <= sub + 1'b1;
                    end
                end
                S_WAITHI: if (s2) st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sio_uart.sv
// sio_uart: register file, status flags and interrupt logic around the baud
// generator, transmitter and receiver. Assumes single-cycle host strobes;
// read side effects apply on the clock edge where rd_en is high.
module sio_uart
    import sio_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              rxd,
    output logic              txd,
    output logic              irq
);
    localparam int HALF_W = DIV_W / 2;

    logic [HALF_W-1:0] div_lo, div_hi;
    logic [DIV_W-1:0]  div;
    fmt_t              fmt;
    logic [1:0]        ien;
    logic [DATA_W-1:0] rbr;
    logic              dr, ovr, pe, fe;
    logic              tick, thre, tx_idle;
    logic              rx_done, rx_pe, rx_fe;
    logic [DATA_W-1:0] rx_data;
    logic              rd_data, rd_stat;

    assign div     = {div_hi, div_lo};
    assign rd_data = rd_en && addr == A_DATA;
    assign rd_stat = rd_en && addr == A_STAT;

    sio_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div(div), .tick(tick)
    );

    sio_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fmt(fmt),
        .load(wr_en && addr == A_DATA), .ldata(wdata),
        .txd(txd), .thr_empty(thre), .idle(tx_idle)
    );

    sio_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fmt(fmt), .rxd(rxd),
        .done(rx_done), .data(rx_data), .perr(rx_pe), .ferr(rx_fe)
    );

    // Host-written configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_lo <= '0;
            div_hi <= '0;
            fmt    <= '0;
            ien    <= '0;
        end else if (wr_en) begin
            case (addr)
                A_DIVL:  div_lo <= wdata[HALF_W-1:0];
                A_DIVH:  div_hi <= wdata[HALF_W-1:0];
                A_FMT:   fmt    <= fmt_t'(wdata[4:0]);
                A_IEN:   ien    <= wdata[1:0];
                default: ;
            endcase
        end
    end

    // Receive holding register and sticky status flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbr <= '0;
            dr  <= 1'b0;
            ovr <= 1'b0;
            pe  <= 1'b0;
            fe  <= 1'b0;
        end else begin
            if (rd_stat) begin
                ovr <= 1'b0;
                pe  <= 1'b0;
                fe  <= 1'b0;
            end
            if (rd_data) dr <= 1'b0;
            if (rx_done) begin
                rbr <= rx_data;
                dr  <= 1'b1;
                if (dr && !rd_data) ovr <= 1'b1;
                if (rx_pe) pe <= 1'b1;
                if (rx_fe) fe <= 1'b1;
            end
        end
    end

    // Read multiplexer
    always_comb begin
        case (addr)
            A_DATA:  rdata = rbr;
            A_DIVL:  rdata = div_lo;
            A_DIVH:  rdata = div_hi;
            A_FMT:   rdata = {3'b000, fmt};
            A_IEN:   rdata = {6'b0, ien};
            A_STAT:  rdata = {2'b00, tx_idle, thre, fe, pe, ovr, dr};
            default: rdata = '0;
        endcase
    end

    assign irq = (ien[0] && dr) || (ien[1] && thre);
endmodule

// File: rtl/sio_uart_chk.sv
// sio_uart_chk: temporal properties of the serial port, bound to sio_uart.
// Assumes it observes the top module's internal flags through the bind.
module sio_uart_chk #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [DIV_W-1:0] div,
    input logic             tick,
    input logic             txd,
    input logic             tx_idle,
    input logic             dr,
    input logic             ovr,
    input logic             fe,
    input logic             rd_data,
    input logic             rx_done,
    input logic             rx_fe
);
    // R3: a divisor held at zero produces no tick
    p_no_tick_zero_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (div == '0 && $past(div) == '0) |-> !tick);

    // R6: an idle transmitter keeps the line high
    p_line_high_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> txd);

    // R4: a start bit only appears when the transmitter is working
    p_start_not_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txd) |-> !tx_idle);

    // R8: reading the data register with no new frame clears data ready
    p_read_clears_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !rx_done) |=> !dr);

    // R9: a frame arriving over unread data flags overrun
    p_overrun_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && dr && !rd_data) |=> ovr);

    // R10: a bad stop bit is recorded in status
    p_frame_err_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_fe) |=> fe);
endmodule

bind sio_uart sio_uart_chk #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .div(div), .tick(tick), .txd(txd),
    .tx_idle(tx_idle), .dr(dr), .ovr(ovr), .fe(fe), .rd_data(rd_data),
    .rx_done(rx_done), .rx_fe(rx_fe)
);

// File: tb/sio_uart_test.sv
// sio_uart_test: directed scenarios for sio_uart, one task per scenario.
module sio_uart_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rxd = 1'b1;
    logic       txd, irq;
    int         vectors = 0;
    int         fails = 0;

    sio_uart uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Frame in line order from bit 0, padded with ones; par 0 none 1 even 2 odd
    function automatic logic [11:0] mk(input logic [7:0] d, input int nd,
                                       input int par, input int stops);
        logic [11:0] f = '1;
        logic p = 1'b0;
        f[0] = 1'b0;
        for (int i = 0; i < nd; i++) begin
            f[1+i] = d[i];
            p = p ^ d[i];
        end
        if (par == 1) f[1+nd] = p;
        if (par == 2) f[1+nd] = ~p;
        return f;
    endfunction

    function automatic int flen(input int nd, input int par, input int stops);
        return 1 + nd + ((par != 0) ? 1 : 0) + stops;
    endfunction

    task automatic cap(input int n, input int dv, output logic [11:0] got);
        int t = 0;
        got = '1;
        while (txd !== 1'b0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (8 * dv) @(negedge clk);
        got[0] = txd;
        for (int k = 1; k < n; k++) begin
            repeat (16 * dv) @(negedge clk);
            got[k] = txd;
        end
    endtask

    task automatic send(input logic [11:0] f, input int n, input int dv);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rxd = f[k];
            repeat (16 * dv - 1) @(negedge clk);
        end
        @(negedge clk);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_idle();
        logic [7:0] s = '0;
        for (int t = 0; t < 5000; t++) begin
            rd(3'd5, s);
            if (s[5]) break;
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(3'd5, v); chk("R1 status", v, 8'h30);
        chk("R1 txd", txd, 1);
        chk("R1 irq", irq, 0);
        rd(3'd1, v); chk("R1 divisor low", v, 0);
        rd(3'd2, v); chk("R1 divisor high", v, 0);
    endtask

    task automatic t_div_regs();
        logic [7:0] v;
        wr(3'd1, 8'h34); wr(3'd2, 8'h12);
        rd(3'd1, v); chk("R2 divisor low readback", v, 8'h34);
        rd(3'd2, v); chk("R2 divisor high readback", v, 8'h12);
        wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    endtask

    task automatic t_div_zero();
        logic [7:0] v;
        logic [11:0] got;
        int lows = 0;
        wr(3'd3, 8'h03);
        wr(3'd0, 8'h55);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        chk("R3 line quiet at zero divisor", lows, 0);
        rd(3'd5, v); chk("R3 byte still held", v, 8'h00);
        wr(3'd1, 8'h01);
        cap(10, 1, got);
        chk("R3 byte sent after divisor set", got, mk(8'h55, 8, 0, 1));
        wait_idle();
    endtask

    task automatic t_tx_period();
        int t = 0;
        wr(3'd1, 8'h03);
        wr(3'd3, 8'h03);
        wr(3'd0, 8'h01);
        while (txd !== 1'b0 && t < 2000) begin @(negedge clk); t++; end
        t = 0;
        while (txd !== 1'b1 && t < 2000) begin @(negedge clk); t++; end
        chk("R2 start bit length at divisor 3", t, 48);
        wait_idle();
        wr(3'd1, 8'h01);
    endtask

    task automatic t_tx_formats();
        logic [11:0] got;
        wr(3'd3, 8'h03); wr(3'd0, 8'hA5);
        cap(10, 1, got); chk("R4 8N1 frame 0xA5", got, mk(8'hA5, 8, 0, 1));
        wait_idle();
        wr(3'd3, 8'h0C); wr(3'd0, 8'h13);
        cap(9, 1, got); chk("R5 5E2 frame 0x13", got, mk(8'h13, 5, 1, 2));
        wait_idle();
        wr(3'd3, 8'h12); wr(3'd0, 8'h5A);
        cap(10, 1, got); chk("R5 7O1 frame 0x5A", got, mk(8'h5A, 7, 2, 1));
        wait_idle();
    endtask

    task automatic t_tx_double();
        logic [11:0] g1, g2;
        logic [7:0] v;
        wr(3'd3, 8'h03);
        fork
            begin
                cap(10, 1, g1);
                cap(10, 1, g2);
            end
            begin
                wr(3'd0, 8'h11);
                wr(3'd0, 8'h22);
                rd(3'd5, v);
                chk("R6 holding full behind busy shifter", v, 8'h00);
            end
        join
        chk("R6 first queued frame", g1, mk(8'h11, 8, 0, 1));
        chk("R6 second queued frame", g2, mk(8'h22, 8, 0, 1));
        wait_idle();
        rd(3'd5, v); chk("R6 idle after both frames", v, 8'h30);
    endtask

    task automatic t_rx_basic();
        logic [7:0] v;
        wr(3'd3, 8'h03);
        send(mk(8'h3C, 8, 0, 1), 10, 1);
        rd(3'd5, v); chk("R8 data ready set", v, 8'h31);
        rd(3'd0, v); chk("R7 received byte 0x3C", v, 8'h3C);
        rd(3'd5, v); chk("R8 data ready cleared by read", v, 8'h30);
        wr(3'd3, 8'h00);
        send(mk(8'hF5, 5, 0, 1), 7, 1);
        rd(3'd0, v); chk("R8 5-bit byte right aligned", v, 8'h15);
        wr(3'd3, 8'h03);
    endtask

    task automatic t_glitch();
        logic [7:0] v;
        @(negedge clk); rxd = 1'b0;
        repeat (5) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        rd(3'd5, v); chk("R7 short start pulse ignored", v, 8'h30);
        send(mk(8'h81, 8, 0, 1), 10, 1);
        rd(3'd0, v); chk("R7 clean frame after pulse", v, 8'h81);
    endtask

    task automatic t_parity();
        logic [7:0] v;
        logic [11:0] f;
        wr(3'd3, 8'h0B);
        send(mk(8'h3C, 8, 1, 1), 11, 1);
        rd(3'd5, v); chk("R10 good even parity", v, 8'h31);
        rd(3'd0, v);
        f = mk(8'h3C, 8, 1, 1);
        f[9] = ~f[9];
        send(f, 11, 1);
        rd(3'd5, v); chk("R10 parity error flagged", v, 8'h35);
        rd(3'd0, v); chk("R10 data kept on parity error", v, 8'h3C);
        rd(3'd5, v); chk("R10 parity flag cleared by status read", v, 8'h30);
    endtask

    task automatic t_framing();
        logic [7:0] v;
        logic [11:0] f;
        wr(3'd3, 8'h07);
        f = mk(8'h66, 8, 0, 2);
        f[9] = 1'b0;
        send(f, 11, 1);
        repeat (40) @(negedge clk);
        rd(3'd5, v); chk("R10 framing error flagged", v, 8'h39);
        rd(3'd0, v); chk("R10 data with framing error", v, 8'h66);
        rd(3'd5, v); chk("R10 no phantom frame after bad stop", v, 8'h30);
        wr(3'd3, 8'h03);
    endtask

    task automatic t_overrun();
        logic [7:0] v;
        send(mk(8'hAA, 8, 0, 1), 10, 1);
        send(mk(8'h55, 8, 0, 1), 10, 1);
        rd(3'd5, v); chk("R9 overrun flagged", v, 8'h33);
        rd(3'd0, v); chk("R9 newer byte kept", v, 8'h55);
        rd(3'd5, v); chk("R9 overrun cleared by status read", v, 8'h30);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        wr(3'd4, 8'h00); @(negedge clk); chk("R11 all masked", irq, 0);
        wr(3'd4, 8'h02); @(negedge clk); chk("R11 holding empty source", irq, 1);
        wr(3'd4, 8'h01); @(negedge clk); chk("R11 rx source, nothing ready", irq, 0);
        send(mk(8'h42, 8, 0, 1), 10, 1);
        chk("R11 rx ready raises irq", irq, 1);
        rd(3'd0, v);
        @(negedge clk); chk("R11 irq drops after data read", irq, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_div_regs();
        t_div_zero();
        t_tx_period();
        t_tx_formats();
        t_tx_double();
        t_rx_basic();
        t_glitch();
        t_parity();
        t_framing();
        t_overrun();
        t_irq();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule